// File: doc/BRIEF.md
# Matrix Key Scanner with Double-Scan Confirmation

This block watches a key matrix of six drive lines by five sense inputs, up to thirty keys. While nothing is pressed it holds the drive lines at a fixed idle pattern and does not count. The first press seen on a sense input starts a scan. The scan drives each line alone for an equal slice of a 288-cycle pass and captures the sense inputs at the end of each slice. Two passes run back to back. When they agree and at least one key is down, the captured map becomes the key data and an active-low read request goes low exactly 615 cycles after the scan began.

A host clears the request by pulsing a read-done input. The block then starts a fresh scan, and keeps doing so as long as any key stays down. A two-bit line-select code can give drive lines 0 and 1 to other use. A two-bit sleep code chooses the idle pattern, so that in sleep only keys on lines held high can wake the scanner. While the serial port reports a transfer in progress, the request line is held high without losing the pending request.

Top module: `keymatrix_scanner`

## Requirements
- R1: While reset is low, the request line is high, all key bits are 0 and the scanner is idle. Release from reset leaves it idle.
- R2: Key bit 5*r+c (r = drive line 0..5, c = sense input 0..4) is set when the key joining line r and input c is down. During a scan, line r is the only line driven high, for 48 cycles.
- R3: When two consecutive passes capture the same non-zero map, the request goes low exactly 615 cycles after the scan started. The key data changes only at that moment.
- R4: When the two passes disagree and the second pass still holds a key, the scan restarts, so the request comes 1230 cycles after the first start.
- R5: If the second pass captures no key, no request is raised and the scanner returns to idle.
- R6: Line-select code 00 uses all six lines. Code 01 gives up line 0. Codes 10 and 11 give up lines 0 and 1. A line given up is always driven low, and its key bits read 0.
- R7: Idle drive pattern by sleep code (bit i = line i): 00 gives all lines high, 01 gives all lines low, 10 gives only line 5 high, 11 gives every line except line 0 high. The pattern is then masked by R6.
- R8: The sleep-acknowledge output is 1 when the sleep code is non-zero and 0 otherwise. Reading key data leaves the sleep code and the idle pattern unchanged.
- R9: A read-done pulse while a request is pending raises the request on the next cycle and starts a new scan. With keys still down the request returns 615 cycles later. With none down the scanner goes idle.
- R10: While the transfer-busy input is high the request line is high. A pending request reappears when it drops.
- R11: A scan starts only from a press on a line that is driven high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock, one period per scan time unit |
| rstN | input | 1 | Asynchronous active-low reset |
| sleepCode | input | 2 | Sleep code, 00 = normal |
| lineSel | input | 2 | Drive-line release code |
| ceBusy | input | 1 | Serial transfer in progress |
| readDone | input | 1 | One-cycle pulse, key data has been read |
| senseIn | input | 5 | Matrix sense inputs |
| scanOut | output | 6 | Matrix drive lines |
| reqN | output | 1 | Active-low key data read request |
| keyData | output | 30 | Confirmed key map |
| sleepAck | output | 1 | 1 while in sleep |

## Verification
The request decision and the transfer-busy override can land in the same cycle. The bench raises ceBusy across the 615-cycle commit point and checks two things: the request stays high, and the new key data is already present. It then checks that the request falls once busy drops. The read-done pulse is also issued while ceBusy is high. The request must then stay high after busy drops, which shows the read was taken, and must return only after a full new scan.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_HOLD} scanState_t;

  // strobes from control to datapath; row index sized for up to 8 drive lines
  typedef struct packed {
    logic       scanning;
    logic       sample;
    logic       secondPass;
    logic [2:0] row;
    logic       commit;
  } scanStrobe_t;
endpackage

// File: rtl/keyscan_ctrl.sv
module keyscan_ctrl
  import keyscan_pkg::*;
#(
  parameter int ROWS      = 6,
  parameter int SLICE     = 48,
  parameter int REQ_DELAY = 615
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        anyPress,
  input  logic        passMatch,
  input  logic        passBAny,
  input  logic        readDone,
  output scanStrobe_t strobe,
  output logic        pending
);
  localparam int CNT_W = $clog2(REQ_DELAY);
  localparam int SL_W  = (SLICE > 1) ? $clog2(SLICE) : 1;

  scanState_t       state;
  logic [CNT_W-1:0] cnt;
  logic [SL_W-1:0]  sliceCnt;
  logic [2:0]       rowIdx;
  logic             secondPass;
  logic             scanDone;
  logic             decide;
  logic             startScan;
  logic             sliceEnd;

  assign decide    = (state == ST_SCAN) && (cnt == CNT_W'(REQ_DELAY - 1));
  assign sliceEnd  = (sliceCnt == SL_W'(SLICE - 1));
  assign startScan = ((state == ST_IDLE) && anyPress) ||
                     ((state == ST_HOLD) && readDone) ||
                     (decide && passBAny && !passMatch);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      sliceCnt   <= '0;
      rowIdx     <= '0;
      secondPass <= 1'b0;
      scanDone   <= 1'b0;
    end else if (startScan) begin
      state      <= ST_SCAN;
      cnt        <= '0;
      sliceCnt   <= '0;
      rowIdx     <= '0;
      secondPass <= 1'b0;
      scanDone   <= 1'b0;
    end else if (decide) begin
      state <= passBAny ? ST_HOLD : ST_IDLE;
    end else if (state == ST_SCAN) begin
      cnt <= cnt + 1'b1;
      if (!scanDone) begin
        if (sliceEnd) begin
          sliceCnt <= '0;
          if (rowIdx == 3'(ROWS - 1)) begin
            rowIdx <= '0;
            if (secondPass) scanDone <= 1'b1;
            else            secondPass <= 1'b1;
          end else begin
            rowIdx <= rowIdx + 1'b1;
          end
        end else begin
          sliceCnt <= sliceCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe.scanning   = (state == ST_SCAN) && !scanDone;
    strobe.sample     = strobe.scanning && sliceEnd;
    strobe.secondPass = secondPass;
    strobe.row        = rowIdx;
    strobe.commit     = decide && passMatch && passBAny;
  end

  assign pending = (state == ST_HOLD);
endmodule

// File: rtl/keyscan_dp.sv
module keyscan_dp
  import keyscan_pkg::*;
#(
  parameter int ROWS = 6,
  parameter int COLS = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  scanStrobe_t        strobe,
  input  logic [COLS-1:0]    senseIn,
  input  logic [1:0]         lineSel,
  input  logic [1:0]         sleepCode,
  output logic [ROWS-1:0]    scanOut,
  output logic [ROWS*COLS-1:0] keyData,
  output logic               anyPress,
  output logic               passMatch,
  output logic               passBAny
);
  localparam int KEYS = ROWS * COLS;

  logic [ROWS-1:0] rowEnable;
  logic [ROWS-1:0] idlePat;
  logic [KEYS-1:0] passA;
  logic [KEYS-1:0] passB;

  always_comb begin
    rowEnable = '1;
    if (lineSel != 2'b00) rowEnable[0] = 1'b0;
    if (lineSel[1])       rowEnable[1] = 1'b0;
  end

  always_comb begin
    case (sleepCode)
      2'b00:   idlePat = '1;
      2'b01:   idlePat = '0;
      2'b10:   idlePat = ROWS'(1) << (ROWS - 1);
      default: idlePat = ~ROWS'(1);
    endcase
  end

  assign scanOut = (strobe.scanning ? (ROWS'(1) << strobe.row) : idlePat) & rowEnable;

  generate
    for (genvar r = 0; r < ROWS; r++) begin : gRow
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          passA[r*COLS +: COLS] <= '0;
          passB[r*COLS +: COLS] <= '0;
        end else if (strobe.sample && (strobe.row == 3'(r))) begin
          if (strobe.secondPass) passB[r*COLS +: COLS] <= senseIn & {COLS{rowEnable[r]}};
          else                   passA[r*COLS +: COLS] <= senseIn & {COLS{rowEnable[r]}};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              keyData <= '0;
    else if (strobe.commit) keyData <= passB;
  end

  assign anyPress  = |senseIn;
  assign passMatch = (passA == passB);
  assign passBAny  = |passB;
endmodule

// File: rtl/keymatrix_scanner.sv
module keymatrix_scanner
  import keyscan_pkg::*;
#(
  parameter int ROWS      = 6,
  parameter int COLS      = 5,
  parameter int SCAN_LEN  = 288,
  parameter int REQ_DELAY = 615
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           sleepCode,
  input  logic [1:0]           lineSel,
  input  logic                 ceBusy,
  input  logic                 readDone,
  input  logic [COLS-1:0]      senseIn,
  output logic [ROWS-1:0]      scanOut,
  output logic                 reqN,
  output logic [ROWS*COLS-1:0] keyData,
  output logic                 sleepAck
);
  localparam int SLICE = SCAN_LEN / ROWS;

  scanStrobe_t strobe;
  logic        anyPress;
  logic        passMatch;
  logic        passBAny;
  logic        pending;

  keyscan_ctrl #(.ROWS(ROWS), .SLICE(SLICE), .REQ_DELAY(REQ_DELAY)) uCtrl (
    .clk(clk), .rstN(rstN), .anyPress(anyPress), .passMatch(passMatch),
    .passBAny(passBAny), .readDone(readDone), .strobe(strobe), .pending(pending)
  );

  keyscan_dp #(.ROWS(ROWS), .COLS(COLS)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .senseIn(senseIn),
    .lineSel(lineSel), .sleepCode(sleepCode), .scanOut(scanOut),
    .keyData(keyData), .anyPress(anyPress), .passMatch(passMatch),
    .passBAny(passBAny)
  );

  assign reqN     = !pending || ceBusy;
  assign sleepAck = |sleepCode;
endmodule

// File: rtl/keymatrix_scanner_chk.sv
module keymatrix_scanner_chk #(
  parameter int ROWS = 6,
  parameter int COLS = 5
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [1:0]           lineSel,
  input logic                 ceBusy,
  input logic                 readDone,
  input logic [ROWS-1:0]      scanOut,
  input logic                 reqN,
  input logic [ROWS*COLS-1:0] keyData
);
  AST_BUSY_KEEPS_REQ_HIGH: assert property (@(posedge clk) disable iff (!rstN) ceBusy |-> reqN); // R10
  AST_LINE0_GIVEN_UP: assert property (@(posedge clk) disable iff (!rstN) (lineSel == 2'b01) |-> !scanOut[0]); // R6
  AST_LINES01_GIVEN_UP: assert property (@(posedge clk) disable iff (!rstN) lineSel[1] |-> (scanOut[1:0] == 2'b00)); // R6
  AST_DATA_ONLY_ON_CONFIRM: assert property (@(posedge clk) disable iff (!rstN) !$stable(keyData) |-> (!reqN || ceBusy)); // R3
  AST_READ_DROPS_REQ: assert property (@(posedge clk) disable iff (!rstN) (readDone && !reqN) |=> reqN); // R9
endmodule

bind keymatrix_scanner keymatrix_scanner_chk #(.ROWS(ROWS), .COLS(COLS)) uChk (
  .clk(clk), .rstN(rstN), .lineSel(lineSel), .ceBusy(ceBusy), .readDone(readDone),
  .scanOut(scanOut), .reqN(reqN), .keyData(keyData)
);

// File: tb/sim_keymatrix_scanner.sv
module sim_keymatrix_scanner;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  sleepCode = 2'b00;
  logic [1:0]  lineSel = 2'b00;
  logic        ceBusy = 1'b0;
  logic        readDone = 1'b0;
  logic [4:0]  senseIn;
  logic [5:0]  scanOut;
  logic        reqN;
  logic [29:0] keyData;
  logic        sleepAck;
  logic [29:0] pressed = '0;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  keymatrix_scanner u0 (
    .clk(clk), .rstN(rstN), .sleepCode(sleepCode), .lineSel(lineSel),
    .ceBusy(ceBusy), .readDone(readDone), .senseIn(senseIn), .scanOut(scanOut),
    .reqN(reqN), .keyData(keyData), .sleepAck(sleepAck)
  );

  // matrix model: input c sees every pressed key whose line is driven high
  always_comb begin
    senseIn = '0;
    for (int r = 0; r < 6; r++)
      for (int c = 0; c < 5; c++)
        if (pressed[r*5+c] && scanOut[r]) senseIn[c] = 1'b1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // posedges from now until reqN is seen low at a negedge
  task automatic waitReq(input int limit, output int n);
    n = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      n++;
      if (!reqN) break;
    end
  endtask

  // true if reqN stays high for cyc cycles
  task automatic quiet(input int cyc, output logic ok);
    ok = 1'b1;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (!reqN) ok = 1'b0;
    end
  endtask

  task automatic pulseRead();
    readDone = 1'b1;
    @(negedge clk);
    readDone = 1'b0;
  endtask

  function automatic logic [5:0] idleOf(input logic [1:0] s, input logic [1:0] l);
    logic [5:0] p, m;
    case (s)
      2'b00: p = 6'h3F;
      2'b01: p = 6'h00;
      2'b10: p = 6'h20;
      default: p = 6'h3E;
    endcase
    m = (l == 2'b00) ? 6'h3F : (l == 2'b01) ? 6'h3E : 6'h3C;
    return p & m;
  endfunction

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    logic ok;
    repeat (3) @(negedge clk);
    chk("R1 reqN in reset", reqN, 1);
    chk("R1 keyData in reset", keyData, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle pattern", scanOut, 6'h3F);
    chk("R8 ack normal", sleepAck, 0);

    // R7 R8: idle patterns over all sleep and line codes
    for (int s = 0; s < 4; s++)
      for (int l = 0; l < 3; l++) begin
        sleepCode = 2'(s);
        lineSel = (l == 2) ? 2'b10 : 2'(l);
        @(negedge clk);
        chk("R7 idle pattern", scanOut, idleOf(sleepCode, lineSel));
        chk("R8 ack", sleepAck, (s != 0));
      end
    sleepCode = 2'b00;
    lineSel = 2'b00;
    @(negedge clk);

    // R2 R3 R9: every single key
    for (int k = 0; k < 30; k++) begin
      pressed = 30'(1) << k;
      waitReq(2000, n);
      chk("R3 latency", n, 616);
      chk("R2 key bit", keyData, 30'(1) << k);
      pulseRead();
      chk("R9 req raised after read", reqN, 1);
      waitReq(2000, n);
      chk("R9 repeat latency", n, 615);
      pressed = '0;
      pulseRead();
      quiet(700, ok);
      chk("R9 idle after release", ok, 1);
      chk("R9 idle lines", scanOut, 6'h3F);
    end

    // R2: scan drives one line at a time, 48 cycles each
    pressed = 30'(1) << 3;
    @(negedge clk);
    for (int r = 0; r < 6; r++) begin
      chk("R2 one line", scanOut, 6'(1) << r);
      repeat (48) @(negedge clk);
    end
    waitReq(2000, n);
    chk("R3 after line walk", n, 616 - 289);
    pressed = '0;
    pulseRead();
    quiet(700, ok);

    // R4: mismatch while still pressed
    pressed = 30'(1) << 11;
    repeat (300) @(negedge clk);
    pressed = pressed | (30'(1) << 20);
    waitReq(3000, n);
    chk("R4 rescan latency", n, 1231 - 300);
    chk("R4 key map", keyData, (30'(1) << 11) | (30'(1) << 20));
    pressed = '0;
    pulseRead();
    quiet(700, ok);

    // R5: short press
    pressed = 30'(1) << 7;
    repeat (100) @(negedge clk);
    pressed = '0;
    quiet(800, ok);
    chk("R5 short press ignored", ok, 1);
    chk("R5 data kept", keyData, (30'(1) << 11) | (30'(1) << 20));

    // R6: line 0 given up
    lineSel = 2'b01;
    pressed = 30'(1) << 2;
    quiet(700, ok);
    chk("R6 line0 key ignored", ok, 1);
    pressed = pressed | (30'(1) << 13);
    waitReq(2000, n);
    chk("R6 latency", n, 616);
    chk("R6 masked map", keyData, 30'(1) << 13);
    pressed = '0;
    pulseRead();
    quiet(700, ok);
    lineSel = 2'b11;
    pressed = (30'(1) << 6) | (30'(1) << 29);
    waitReq(2000, n);
    chk("R6 lines01 map", keyData, 30'(1) << 29);
    pressed = '0;
    pulseRead();
    quiet(700, ok);
    lineSel = 2'b00;

    // R11 R8: sleep with only line 5 high
    sleepCode = 2'b10;
    pressed = 30'(1) << 0;
    quiet(700, ok);
    chk("R11 no wake from low line", ok, 1);
    pressed = pressed | (30'(1) << 27);
    waitReq(2000, n);
    chk("R11 wake latency", n, 616);
    chk("R11 map", keyData, (30'(1) << 0) | (30'(1) << 27));
    pressed = '0;
    pulseRead();
    quiet(700, ok);
    chk("R8 still asleep", sleepAck, 1);
    chk("R8 sleep pattern", scanOut, 6'h20);
    sleepCode = 2'b00;

    // R10: busy across the commit, then read during busy
    pressed = 30'(1) << 17;
    repeat (600) @(negedge clk);
    ceBusy = 1'b1;
    repeat (30) @(negedge clk);
    chk("R10 held high", reqN, 1);
    chk("R10 data committed", keyData, 30'(1) << 17);
    ceBusy = 1'b0;
    @(negedge clk);
    chk("R10 reappears", reqN, 0);
    ceBusy = 1'b1;
    pulseRead();
    ceBusy = 1'b0;
    @(negedge clk);
    chk("R10 read taken during busy", reqN, 1);
    waitReq(2000, n);
    chk("R9 rescan after busy read", n, 614);

    // R1: reset while pending
    rstN = 1'b0;
    @(negedge clk);
    chk("R1 reset reqN", reqN, 1);
    chk("R1 reset data", keyData, 0);
    pressed = '0;
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", scanOut, 6'h3F);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule